// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor load/store port and a slower backing memory. It keeps a small number of memory blocks in two ways per set. It answers hits combinationally, in the same cycle as the request. On a miss it stalls the requester while it moves whole blocks to and from memory. Each set holds one recency bit. A miss fills an empty way when the set has one. Otherwise it replaces the way that was used less recently. Writes stay in the cache and mark the block dirty. A dirty block is copied back to memory only when it is evicted.

The requester presents a read or write strobe with an address, write data and byte enables. It must hold the request unchanged while the stall output is high. When the miss has been serviced, the held request is answered as a hit. The memory side is a request/acknowledge port that carries one whole block per transfer. The write flag on that port distinguishes a writeback from a fill.

Top module: `cache_2way`

## Requirements
- R1: The address is split as unsigned fields. Bits [1:0] pick a byte within a word and are ignored. The next log2(WORDS) bits pick the word within the block. The next log2(SETS) bits pick the set. The remaining upper bits form the tag. Blocks with equal set bits and different tags compete for the same two ways.
- R2: Reset clears every valid bit. After reset, with no request, cpuHit, cpuStall and memReq are 0. The first access to any address is a miss.
- R3: A read that matches a valid way of its set returns the addressed word on cpuRData in the same cycle, with cpuHit=1 and cpuStall=0.
- R4: A miss raises cpuStall with cpuHit=0 from its first cycle until the refill ends. The held request then completes as a hit in the cycle after the fill acknowledge.
- R5: When the selected set has an invalid way, a miss fills the lowest-numbered invalid way and evicts nothing.
- R6: When both ways are valid, a miss replaces the way not used most recently. Every read or write hit counts as a use.
- R7: A write hit replaces only the bytes whose cpuBe bit is set (bit i covers cpuWData bits 8i+7:8i). It marks the block dirty and makes no memory request.
- R8: Evicting a dirty block first issues one writeback: memWe=1, memAddr = the victim's {tag,set}, and memWData = its block contents. The fill follows. A clean victim is dropped without a writeback.
- R9: A fill requests with memWe=0 and memAddr = the requested {tag,set}. It loads memRData when memAck is 1, and word w of the block lies at bits 32w+31:32w.
- R10: Once memReq is raised, memReq, memWe and memAddr stay unchanged until memAck.
- R11: With blocks 0, 8, 0, 1, 16, 0 on the default geometry (4 sets), the six accesses give miss, miss, hit, miss, miss (evicting 8), hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuRd | input | 1 | Read request |
| cpuWr | input | 1 | Write request |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWData | input | 32 | Write data |
| cpuBe | input | 4 | Byte enables for writes |
| cpuRData | output | 32 | Read data, valid with cpuHit |
| cpuHit | output | 1 | Request served this cycle |
| cpuStall | output | 1 | Hold the request; miss in service |
| memReq | output | 1 | Block transfer request |
| memWe | output | 1 | 1 = writeback, 0 = fill |
| memAddr | output | ADDR_W-OFF_W | Block address {tag,set} |
| memWData | output | 32*WORDS | Block being written back |
| memRData | input | 32*WORDS | Block returned for a fill |
| memAck | input | 1 | Transfer done, one-cycle pulse |

## Verification
Hit, stall and read data are combinational, so they are due in the same cycle as the request. The bench samples them 5 ns after the falling edge on which it drove the request. A miss must show stall in that first sample. The bench then steps one falling edge at a time until stall drops, and in that sample expects the replayed hit. The bench counts fills and writebacks from the memory side. It compares those counts, the block addresses and the written-back contents only after the rising edge that commits the access. A reference model built from the requirements predicts each outcome.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef struct packed {
    logic touch;       // hit: update recency
    logic wrHit;       // hit: merge write bytes, set dirty
    logic grabVictim;  // miss: latch chosen victim way
    logic selWb;       // drive victim block address to memory
    logic fill;        // install returned block
  } dpCtl_t;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} ctlState_t;
endpackage

// File: rtl/cache_dp.sv
module cache_dp
  import cache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORDS  = 2,
  parameter int SETS   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCtl_t                        ctl,
  input  logic [ADDR_W-1:0]             cpuAddr,
  input  logic [31:0]                   cpuWData,
  input  logic [3:0]                    cpuBe,
  input  logic [32*WORDS-1:0]           memRData,
  output logic                          hit,
  output logic                          victimDirty,
  output logic [31:0]                   cpuRData,
  output logic [ADDR_W-$clog2(WORDS)-3:0] memAddr,
  output logic [32*WORDS-1:0]           memWData
);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = WSEL_W + 2;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BLK_W  = 32 * WORDS;

  logic [TAG_W-1:0] tagQ  [SETS][2];
  logic [BLK_W-1:0] dataQ [SETS][2];
  logic [1:0]       validQ [SETS];
  logic [1:0]       dirtyQ [SETS];
  logic [SETS-1:0]  lruQ;
  logic             vicQ;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tagIn;
  logic [WSEL_W-1:0] wsel;
  logic [1:0]        hitVec;
  logic              hitWay;
  logic              vicNow;
  logic [BLK_W-1:0]  hitBlk;
  logic [BLK_W-1:0]  wrBlk;
  logic              unusedLow;

  assign idx       = cpuAddr[OFF_W +: IDX_W];
  assign tagIn     = cpuAddr[ADDR_W-1 -: TAG_W];
  assign wsel      = cpuAddr[2 +: WSEL_W];
  assign unusedLow = ^cpuAddr[1:0];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hitVec[w] = validQ[idx][w] && (tagQ[idx][w] == tagIn);
  end

  assign hit    = |hitVec;
  assign hitWay = hitVec[1];
  assign vicNow = !validQ[idx][0] ? 1'b0 :
                  !validQ[idx][1] ? 1'b1 : lruQ[idx];
  assign victimDirty = validQ[idx][vicNow] && dirtyQ[idx][vicNow];

  assign hitBlk   = dataQ[idx][hitWay];
  assign cpuRData = hitBlk[wsel*32 +: 32];
  assign memAddr  = ctl.selWb ? {tagQ[idx][vicQ], idx} : {tagIn, idx};
  assign memWData = dataQ[idx][vicQ];

  always_comb begin
    wrBlk = hitBlk;
    for (int b = 0; b < 4; b++) begin
      if (cpuBe[b]) wrBlk[wsel*32 + b*8 +: 8] = cpuWData[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        dirtyQ[s] <= '0;
      end
      lruQ <= '0;
      vicQ <= 1'b0;
    end else begin
      if (ctl.grabVictim) vicQ <= vicNow;
      if (ctl.touch) lruQ[idx] <= ~hitWay;
      if (ctl.wrHit) dirtyQ[idx][hitWay] <= 1'b1;
      if (ctl.fill) begin
        validQ[idx][vicQ] <= 1'b1;
        dirtyQ[idx][vicQ] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.wrHit) dataQ[idx][hitWay] <= wrBlk;
    if (ctl.fill) begin
      dataQ[idx][vicQ] <= memRData;
      tagQ[idx][vicQ]  <= tagIn;
    end
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cpuRd,
  input  logic   cpuWr,
  input  logic   hit,
  input  logic   victimDirty,
  input  logic   memAck,
  output dpCtl_t ctl,
  output logic   cpuHit,
  output logic   cpuStall,
  output logic   memReq,
  output logic   memWe
);
  ctlState_t st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    ctl      = '0;
    cpuHit   = 1'b0;
    cpuStall = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    nxt      = st;
    unique case (st)
      S_IDLE: begin
        if (cpuRd || cpuWr) begin
          if (hit) begin
            cpuHit    = 1'b1;
            ctl.touch = 1'b1;
            ctl.wrHit = cpuWr;
          end else begin
            cpuStall       = 1'b1;
            ctl.grabVictim = 1'b1;
            nxt            = victimDirty ? S_WB : S_FILL;
          end
        end
      end
      S_WB: begin
        cpuStall  = 1'b1;
        memReq    = 1'b1;
        memWe     = 1'b1;
        ctl.selWb = 1'b1;
        if (memAck) nxt = S_FILL;
      end
      S_FILL: begin
        cpuStall = 1'b1;
        memReq   = 1'b1;
        if (memAck) begin
          ctl.fill = 1'b1;
          nxt      = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/cache_2way.sv
module cache_2way
  import cache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORDS  = 2,
  parameter int SETS   = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cpuRd,
  input  logic                            cpuWr,
  input  logic [ADDR_W-1:0]               cpuAddr,
  input  logic [31:0]                     cpuWData,
  input  logic [3:0]                      cpuBe,
  output logic [31:0]                     cpuRData,
  output logic                            cpuHit,
  output logic                            cpuStall,
  output logic                            memReq,
  output logic                            memWe,
  output logic [ADDR_W-$clog2(WORDS)-3:0] memAddr,
  output logic [32*WORDS-1:0]             memWData,
  input  logic [32*WORDS-1:0]             memRData,
  input  logic                            memAck
);
  dpCtl_t ctl;
  logic   hit;
  logic   victimDirty;

  cache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .hit(hit), .victimDirty(victimDirty), .memAck(memAck),
    .ctl(ctl), .cpuHit(cpuHit), .cpuStall(cpuStall),
    .memReq(memReq), .memWe(memWe)
  );

  cache_dp #(.ADDR_W(ADDR_W), .WORDS(WORDS), .SETS(SETS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuBe(cpuBe), .memRData(memRData),
    .hit(hit), .victimDirty(victimDirty), .cpuRData(cpuRData),
    .memAddr(memAddr), .memWData(memWData)
  );
endmodule

// File: rtl/cache_2way_chk.sv
module cache_2way_chk #(
  parameter int BADDR_W = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               cpuRd,
  input logic               cpuWr,
  input logic               cpuHit,
  input logic               cpuStall,
  input logic               memReq,
  input logic               memWe,
  input logic               memAck,
  input logic [BADDR_W-1:0] memAddr
);
  p_hit_not_stalled_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuHit |-> !cpuStall);

  p_req_means_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> cpuStall);

  p_replay_hits_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck && (cpuRd || cpuWr)) |=> cpuHit);

  p_req_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr)));

  p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck) |=> (memReq && !memWe));

  p_hit_quiet_mem_r7: assert property (@(posedge clk) disable iff (!rstN)
    cpuHit |-> !memReq);
endmodule

bind cache_2way cache_2way_chk #(.BADDR_W(ADDR_W - $clog2(WORDS) - 2)) u_chk (
  .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuHit(cpuHit),
  .cpuStall(cpuStall), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr)
);

// File: tb/sim_cache_2way.sv
`timescale 1ns/1ps
module sim_cache_2way;
  localparam int ADDR_W = 10;
  localparam int WORDS  = 2;
  localparam int SETS   = 4;
  localparam int NBLK   = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuRd = 1'b0, cpuWr = 1'b0;
  logic [9:0]  cpuAddr = '0;
  logic [31:0] cpuWData = '0;
  logic [3:0]  cpuBe = '0;
  logic [31:0] cpuRData;
  logic        cpuHit, cpuStall, memReq, memWe;
  logic [6:0]  memAddr;
  logic [63:0] memWData;
  logic [63:0] memRData = '0;
  logic        memAck = 1'b0;

  int nChk = 0, nFail = 0;
  int wbCnt = 0, fillCnt = 0, lat = 0;
  logic [6:0] lastWbBlk = '0, lastFillBlk = '0;

  logic [63:0] store  [NBLK];
  logic [31:0] golden [2*NBLK];
  logic [4:0]  rTag [SETS][2];
  bit          rV [SETS][2];
  bit          rD [SETS][2];
  bit          rL [SETS];

  always #10 clk = ~clk;

  cache_2way #(.ADDR_W(ADDR_W), .WORDS(WORDS), .SETS(SETS)) u0 (
    .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuBe(cpuBe), .cpuRData(cpuRData), .cpuHit(cpuHit),
    .cpuStall(cpuStall), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData), .memAck(memAck)
  );

  function automatic logic [31:0] initWord(int wa);
    return 32'h1000_0000 + 32'(wa) * 32'h0001_0101;
  endfunction

  // backing store: answers each request after a short latency, one-cycle ack
  always @(negedge clk) begin
    if (!rstN) begin
      memAck = 1'b0; lat = 0;
    end else if (memAck) begin
      memAck = 1'b0;
    end else if (memReq) begin
      if (lat == 2) begin
        lat = 0;
        memAck = 1'b1;
        if (memWe) begin
          store[memAddr] = memWData; wbCnt++; lastWbBlk = memAddr;
        end else begin
          memRData = store[memAddr]; fillCnt++; lastFillBlk = memAddr;
        end
      end else lat++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doAccess(input bit isWr, input logic [9:0] a, input logic [31:0] wd,
                          input logic [3:0] be, input string tg, output bit sawHit);
    int blk, idx, t, wa, way, wb0, f0, n;
    bit expHit, expWb;
    int expWbBlk;
    logic [31:0] expRd, nw;
    blk = int'(a[9:3]); idx = blk % SETS; t = blk / SETS; wa = int'(a[9:2]);
    expHit = 1'b0; expWb = 1'b0; expWbBlk = 0; way = 0;
    for (int w = 0; w < 2; w++)
      if (rV[idx][w] && rTag[idx][w] == 5'(t)) begin expHit = 1'b1; way = w; end
    if (!expHit) begin
      way = !rV[idx][0] ? 0 : !rV[idx][1] ? 1 : int'(rL[idx]);
      if (rV[idx][way] && rD[idx][way]) begin
        expWb = 1'b1; expWbBlk = int'(rTag[idx][way]) * SETS + idx;
      end
      rV[idx][way] = 1'b1; rD[idx][way] = 1'b0; rTag[idx][way] = 5'(t);
    end
    rL[idx] = (way == 0);
    expRd = golden[wa];
    if (isWr) begin
      rD[idx][way] = 1'b1;
      nw = golden[wa];
      for (int b = 0; b < 4; b++) if (be[b]) nw[b*8 +: 8] = wd[b*8 +: 8];
      golden[wa] = nw;
    end

    @(negedge clk);
    cpuRd = !isWr; cpuWr = isWr; cpuAddr = a; cpuWData = wd; cpuBe = be;
    wb0 = wbCnt; f0 = fillCnt;
    #5;
    sawHit = cpuHit;
    if (expHit)
      chk(cpuHit && !cpuStall, tg, "hit in first cycle (R3)", {cpuHit, cpuStall}, 2'b10);
    else
      chk(!cpuHit && cpuStall, tg, "miss stalls (R4)", {cpuHit, cpuStall}, 2'b01);
    n = 0;
    while (cpuStall && n < 60) begin @(negedge clk); #5; n++; end
    chk(cpuHit && !cpuStall, "R4", "replayed access hits", {cpuHit, cpuStall}, 2'b10);
    if (!isWr) chk(cpuRData == expRd, "R3", "read data", cpuRData, expRd);
    @(posedge clk); #2;
    cpuRd = 1'b0; cpuWr = 1'b0;
    chk((wbCnt - wb0) == int'(expWb), "R8", "writeback count", wbCnt - wb0, expWb);
    chk((fillCnt - f0) == int'(!expHit), "R9", "fill count", fillCnt - f0, !expHit);
    if (!expHit) chk(lastFillBlk == 7'(blk), "R9", "fill address", lastFillBlk, blk);
    if (expWb) begin
      chk(lastWbBlk == 7'(expWbBlk), "R8", "writeback address", lastWbBlk, expWbBlk);
      chk(store[expWbBlk] == {golden[2*expWbBlk+1], golden[2*expWbBlk]}, "R8",
          "written-back block", store[expWbBlk],
          {golden[2*expWbBlk+1], golden[2*expWbBlk]});
    end
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    bit h;
    bit [5:0] seq;
    int seed;
    for (int i = 0; i < NBLK; i++) begin
      store[i] = {initWord(2*i+1), initWord(2*i)};
      golden[2*i] = initWord(2*i); golden[2*i+1] = initWord(2*i+1);
    end
    for (int s = 0; s < SETS; s++) begin
      rL[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin rV[s][w] = 1'b0; rD[s][w] = 1'b0; rTag[s][w] = '0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #5;
    chk(!cpuHit && !cpuStall && !memReq, "R2", "idle outputs after reset",
        {cpuHit, cpuStall, memReq}, 3'b000);

    // R11: blocks 0,8,0,1,16,0 -> miss,miss,hit,miss,miss,hit; R2 first access misses
    doAccess(1'b0, 10'd0,   '0, '0, "R2",  h); seq[5] = h;
    doAccess(1'b0, 10'd64,  '0, '0, "R11", h); seq[4] = h;
    doAccess(1'b0, 10'd0,   '0, '0, "R11", h); seq[3] = h;
    doAccess(1'b0, 10'd8,   '0, '0, "R11", h); seq[2] = h;
    doAccess(1'b0, 10'd128, '0, '0, "R11", h); seq[1] = h;
    doAccess(1'b0, 10'd0,   '0, '0, "R11", h); seq[0] = h;
    chk(seq == 6'b001001, "R11", "hit pattern", seq, 6'b001001);
    doAccess(1'b0, 10'd64,  '0, '0, "R11", h);
    chk(!h, "R11", "block 8 was evicted", h, 0);

    // R1: byte bits ignored, other word of the block hits, same set other tag conflicts
    doAccess(1'b0, 10'd3,   '0, '0, "R1", h);
    chk(h, "R1", "byte bits ignored", h, 1);
    doAccess(1'b0, 10'd4,   '0, '0, "R1", h);
    chk(h, "R1", "second word of block", h, 1);

    // R5: set 2 empty -> two blocks coexist
    doAccess(1'b0, 10'd16,  '0, '0, "R5", h);
    doAccess(1'b0, 10'd80,  '0, '0, "R5", h);
    doAccess(1'b0, 10'd16,  '0, '0, "R5", h);
    chk(h, "R5", "first block kept after second fill", h, 1);

    // R6 + R7: write hit to block 10 makes it recent; block 18 evicts block 2
    doAccess(1'b1, 10'd84, 32'hDEAD_BEEF, 4'b0101, "R7", h);
    doAccess(1'b0, 10'd84,  '0, '0, "R7", h);
    chk(h, "R7", "write hit then read hit", h, 1);
    doAccess(1'b0, 10'd144, '0, '0, "R6", h);
    doAccess(1'b0, 10'd84,  '0, '0, "R6", h);
    chk(h, "R6", "written block survived", h, 1);
    doAccess(1'b0, 10'd16,  '0, '0, "R6", h);
    chk(!h, "R6", "LRU block evicted", h, 0);
    // R8: block 10 is now LRU and dirty -> writeback before fill
    doAccess(1'b0, 10'd208, '0, '0, "R8", h);

    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < 400; i++) begin
      logic [9:0] a;
      logic [3:0] be;
      a = {2'b00, 5'($urandom % 32), 1'($urandom), 2'($urandom)};
      be = 4'($urandom % 15 + 1);
      doAccess(1'($urandom % 3 == 0), a, $urandom, be, "R6", h);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule